// File: doc/BRIEF.md
# SIMT Divergence Mask Controller

This block steers the active-lane mask of one warp whose lanes share a single instruction stream. Each lane carries its own data and behaves as if it had its own program counter, yet only one instruction is fetched and issued per cycle, and every active lane executes it. When a conditional branch arrives with a per-lane predicate, the controller decides whether the active lanes agree. If they agree, it redirects the program counter and leaves the mask untouched. If they disagree, it serializes the two sides: the taken side runs first with the other lanes masked off, then the fall-through side runs under the complementary mask, and finally the original mask is restored at the reconvergence PC.

Nested divergence is tracked in a small last-in, first-out stack. Each entry holds the reconvergence PC, the pending mask and start PC of the side not yet run, the mask that was active before the split, and one bit recording which side is running. A path-done pulse from the pipeline, raised when the running side reaches the reconvergence PC, advances the top entry. A warp that splits evenly therefore spends two passes of issue slots to produce one result.

The controller is a three-state machine. CONVERGED means the stack is empty. DIVERGED means at least one entry is live. OVERFLOW means a divergent branch arrived while the stack was full. The transitions are: CONVERGED to DIVERGED on a divergent branch (push); DIVERGED to DIVERGED on a nested split, or on a path-done that switches sides or pops an inner entry; DIVERGED to CONVERGED on a path-done that pops the last entry; CONVERGED or DIVERGED to OVERFLOW on a divergent branch while the stack holds DEPTH entries. OVERFLOW is left only through reset.

Top module: `simt_div_ctrl`

## Requirements
- R1: After reset, active_mask is all ones, next_pc equals RESET_PC (default 0), and diverged and stack_overflow are both 0.
- R2: A branch whose predicate is 1 on every active lane sets next_pc to br_target_pc one cycle later. A branch whose predicate is 0 on every active lane sets next_pc to br_fall_pc. In both cases active_mask and diverged are unchanged and no stack entry is created.
- R3: Bit i of br_pred and of active_mask belongs to lane i. When the active lanes disagree, in the next cycle active_mask equals br_pred AND the old mask, next_pc equals br_target_pc, and diverged is 1. The taken side always runs first.
- R4: The first path_done after a split sets active_mask to the lanes that were active with predicate 0 at the branch, and sets next_pc to that branch's br_fall_pc.
- R5: The second path_done after a split restores the mask that was active before the branch and sets next_pc to its br_reconv_pc. diverged drops to 0 when this empties the stack.
- R6: Predicate bits of inactive lanes have no effect on whether a branch diverges or on the resulting mask.
- R7: Nested splits unwind in last-in, first-out order. The inner split finishes both its sides and reconverges before the outer split's pending side starts.
- R8: A path_done while the stack is empty is ignored: next_pc and active_mask stay unchanged.
- R9: When br_valid and path_done are high in the same cycle, the path_done is served and the branch is discarded.
- R10: A divergent branch that arrives while DEPTH entries are held sets stack_overflow to 1. From then until reset, active_mask and next_pc stay frozen and all branch and path_done inputs are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| br_valid | input | 1 | A conditional branch is presented this cycle |
| br_pred | input | LANES | Per-lane branch predicate, 1 = taken |
| br_target_pc | input | PC_W | Start PC of the taken side |
| br_fall_pc | input | PC_W | Start PC of the fall-through side |
| br_reconv_pc | input | PC_W | PC where both sides rejoin |
| path_done | input | 1 | The running side has reached its reconvergence PC |
| next_pc | output | PC_W | PC the shared front end must fetch next |
| active_mask | output | LANES | Lanes enabled for the issued instruction |
| diverged | output | 1 | At least one split is outstanding |
| stack_overflow | output | 1 | A split was refused because the stack was full (sticky) |

## Verification
The bench uses the default 32 lanes, 32-bit PCs and an 8-entry stack. With these values it can build eight nested splits, each dropping one lane from the mask, then send a ninth split into a full stack with 24 lanes still active. This reaches the overflow freeze without exhausting the lanes. The 32-lane width also leaves room for a two-level nest whose inner split falls entirely inside the outer taken half, so the last-in, first-out unwind order can be observed. The same width allows a branch whose inactive-lane predicate bits contradict its active ones.

// File: rtl/simt_div_pkg.sv
package simt_div_pkg;

    // Controller states
    typedef enum logic [1:0] {
        S_CONVERGED = 2'd0,
        S_DIVERGED  = 2'd1,
        S_OVERFLOW  = 2'd2
    } ctrl_state_e;

    // How the active lanes resolve a branch
    typedef enum logic [1:0] {
        SPLIT_NONE_TAKEN = 2'd0,
        SPLIT_ALL_TAKEN  = 2'd1,
        SPLIT_BOTH       = 2'd2
    } split_kind_e;

endpackage

// File: rtl/simt_lane_split.sv
module simt_lane_split
    import simt_div_pkg::*;
#(
    parameter int LANES = 32
) (
    input  logic [LANES-1:0] pred,
    input  logic [LANES-1:0] cur_mask,
    output logic [LANES-1:0] taken_mask,
    output logic [LANES-1:0] other_mask,
    output split_kind_e      kind
);

    logic any_taken;
    logic any_other;

    // Only the lanes that are currently active take part in the vote
    assign taken_mask = pred & cur_mask;
    assign other_mask = ~pred & cur_mask;
    assign any_taken  = |taken_mask;
    assign any_other  = |other_mask;

    always_comb begin
        if (any_taken && any_other) begin
            kind = SPLIT_BOTH;
        end else if (any_taken) begin
            kind = SPLIT_ALL_TAKEN;
        end else begin
            kind = SPLIT_NONE_TAKEN;
        end
    end

endmodule

// File: rtl/simt_recon_stack.sv
module simt_recon_stack #(
    parameter int LANES = 32,
    parameter int PC_W  = 32,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic             flip,
    input  logic [PC_W-1:0]  in_rc_pc,
    input  logic [PC_W-1:0]  in_alt_pc,
    input  logic [LANES-1:0] in_alt_mask,
    input  logic [LANES-1:0] in_outer_mask,
    output logic [PC_W-1:0]  top_rc_pc,
    output logic [PC_W-1:0]  top_alt_pc,
    output logic [LANES-1:0] top_alt_mask,
    output logic [LANES-1:0] top_outer_mask,
    output logic             top_second,
    output logic             empty,
    output logic             full,
    output logic             single
);

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [CNT_W-1:0] cnt_q;
    logic [IDX_W-1:0] top_idx;
    logic [IDX_W-1:0] wr_idx;

    logic [PC_W-1:0]  rc_pc_q     [DEPTH];
    logic [PC_W-1:0]  alt_pc_q    [DEPTH];
    logic [LANES-1:0] alt_mask_q  [DEPTH];
    logic [LANES-1:0] outer_mask_q[DEPTH];
    logic [DEPTH-1:0] second_q;

    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == CNT_W'(DEPTH));
    assign single  = (cnt_q == CNT_W'(1));
    assign wr_idx  = IDX_W'(cnt_q);
    assign top_idx = IDX_W'(cnt_q - CNT_W'(1));

    assign top_rc_pc      = rc_pc_q[top_idx];
    assign top_alt_pc     = alt_pc_q[top_idx];
    assign top_alt_mask   = alt_mask_q[top_idx];
    assign top_outer_mask = outer_mask_q[top_idx];
    assign top_second     = second_q[top_idx];

    // Occupancy counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (push && !full) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end else if (pop && !empty) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    // One slice of storage per entry
    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
        logic wr_en;
        logic flip_en;
        assign wr_en   = push && !full && (wr_idx == IDX_W'(e));
        assign flip_en = flip && !empty && (top_idx == IDX_W'(e));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rc_pc_q[e]      <= '0;
                alt_pc_q[e]     <= '0;
                alt_mask_q[e]   <= '0;
                outer_mask_q[e] <= '0;
                second_q[e]     <= 1'b0;
            end else if (wr_en) begin
                rc_pc_q[e]      <= in_rc_pc;
                alt_pc_q[e]     <= in_alt_pc;
                alt_mask_q[e]   <= in_alt_mask;
                outer_mask_q[e] <= in_outer_mask;
                second_q[e]     <= 1'b0;
            end else if (flip_en) begin
                second_q[e]     <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/simt_div_ctrl.sv
module simt_div_ctrl
    import simt_div_pkg::*;
#(
    parameter int              LANES    = 32,
    parameter int              PC_W     = 32,
    parameter int              DEPTH    = 8,
    parameter logic [PC_W-1:0] RESET_PC = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             br_valid,
    input  logic [LANES-1:0] br_pred,
    input  logic [PC_W-1:0]  br_target_pc,
    input  logic [PC_W-1:0]  br_fall_pc,
    input  logic [PC_W-1:0]  br_reconv_pc,
    input  logic             path_done,
    output logic [PC_W-1:0]  next_pc,
    output logic [LANES-1:0] active_mask,
    output logic             diverged,
    output logic             stack_overflow
);

    ctrl_state_e      state_q, state_d;
    logic [LANES-1:0] mask_q, mask_d;
    logic [PC_W-1:0]  pc_q, pc_d;

    logic [LANES-1:0] taken_mask, other_mask;
    split_kind_e      kind;

    logic             push, pop, flip;
    logic [PC_W-1:0]  top_rc_pc, top_alt_pc;
    logic [LANES-1:0] top_alt_mask, top_outer_mask;
    logic             top_second, stk_empty, stk_full, stk_single;

    simt_lane_split #(.LANES(LANES)) u_split (
        .pred       (br_pred),
        .cur_mask   (mask_q),
        .taken_mask (taken_mask),
        .other_mask (other_mask),
        .kind       (kind)
    );

    simt_recon_stack #(.LANES(LANES), .PC_W(PC_W), .DEPTH(DEPTH)) u_stack (
        .clk            (clk),
        .rst_n          (rst_n),
        .push           (push),
        .pop            (pop),
        .flip           (flip),
        .in_rc_pc       (br_reconv_pc),
        .in_alt_pc      (br_fall_pc),
        .in_alt_mask    (other_mask),
        .in_outer_mask  (mask_q),
        .top_rc_pc      (top_rc_pc),
        .top_alt_pc     (top_alt_pc),
        .top_alt_mask   (top_alt_mask),
        .top_outer_mask (top_outer_mask),
        .top_second     (top_second),
        .empty          (stk_empty),
        .full           (stk_full),
        .single         (stk_single)
    );

    // State register together with the mask and PC it steers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_CONVERGED;
            mask_q  <= '1;
            pc_q    <= RESET_PC;
        end else begin
            state_q <= state_d;
            mask_q  <= mask_d;
            pc_q    <= pc_d;
        end
    end

    // Transitions and stack commands
    always_comb begin
        state_d = state_q;
        mask_d  = mask_q;
        pc_d    = pc_q;
        push    = 1'b0;
        pop     = 1'b0;
        flip    = 1'b0;
        unique case (state_q)
            S_CONVERGED, S_DIVERGED: begin
                if (path_done && !stk_empty) begin
                    if (!top_second) begin
                        // taken side finished: start the pending side
                        flip   = 1'b1;
                        mask_d = top_alt_mask;
                        pc_d   = top_alt_pc;
                    end else begin
                        // both sides finished: reconverge
                        pop    = 1'b1;
                        mask_d = top_outer_mask;
                        pc_d   = top_rc_pc;
                        if (stk_single) begin
                            state_d = S_CONVERGED;
                        end
                    end
                end else if (br_valid && !path_done) begin
                    unique case (kind)
                        SPLIT_NONE_TAKEN: pc_d = br_fall_pc;
                        SPLIT_ALL_TAKEN:  pc_d = br_target_pc;
                        SPLIT_BOTH: begin
                            if (stk_full) begin
                                state_d = S_OVERFLOW;
                            end else begin
                                push    = 1'b1;
                                mask_d  = taken_mask;
                                pc_d    = br_target_pc;
                                state_d = S_DIVERGED;
                            end
                        end
                    endcase
                end
            end
            S_OVERFLOW: begin
                state_d = S_OVERFLOW;
            end
            default: begin
                state_d = S_OVERFLOW;
            end
        endcase
    end

    // Outputs
    assign next_pc        = pc_q;
    assign active_mask    = mask_q;
    assign diverged       = (state_q == S_DIVERGED);
    assign stack_overflow = (state_q == S_OVERFLOW);

endmodule

// File: rtl/simt_div_chk.sv
module simt_div_chk #(
    parameter int LANES = 32,
    parameter int PC_W  = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             br_valid,
    input logic [LANES-1:0] br_pred,
    input logic [PC_W-1:0]  br_target_pc,
    input logic             path_done,
    input logic [PC_W-1:0]  next_pc,
    input logic [LANES-1:0] active_mask,
    input logic             diverged,
    input logic             stack_overflow
);

    // R3
    mask_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active_mask != '0);

    // R3
    partial_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        diverged |-> (active_mask != '1));

    // R2
    uniform_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && !path_done && !stack_overflow && ((~br_pred & active_mask) == '0))
        |=> (active_mask == $past(active_mask)) && (next_pc == $past(br_target_pc))
            && (diverged == $past(diverged)));

    // R3
    split_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && !path_done && !stack_overflow
         && ((br_pred & active_mask) != '0) && ((~br_pred & active_mask) != '0))
        |=> stack_overflow
            || (diverged && (active_mask == $past(br_pred & active_mask))
                && (next_pc == $past(br_target_pc))));

    // R8
    idle_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (path_done && !diverged && !stack_overflow)
        |=> $stable(active_mask) && $stable(next_pc));

    // R10
    overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stack_overflow |=> stack_overflow && $stable(active_mask) && $stable(next_pc));

endmodule

bind simt_div_ctrl simt_div_chk #(.LANES(LANES), .PC_W(PC_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .br_valid       (br_valid),
    .br_pred        (br_pred),
    .br_target_pc   (br_target_pc),
    .path_done      (path_done),
    .next_pc        (next_pc),
    .active_mask    (active_mask),
    .diverged       (diverged),
    .stack_overflow (stack_overflow)
);

// File: tb/simt_div_ctrl_tb.sv
`timescale 1ns/1ps
module simt_div_ctrl_tb;

    localparam int LANES = 32;
    localparam int PC_W  = 32;
    localparam int DEPTH = 8;
    localparam logic [LANES-1:0] FULL = '1;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             br_valid;
    logic [LANES-1:0] br_pred;
    logic [PC_W-1:0]  br_target_pc, br_fall_pc, br_reconv_pc;
    logic             path_done;
    logic [PC_W-1:0]  next_pc;
    logic [LANES-1:0] active_mask;
    logic             diverged, stack_overflow;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    simt_div_ctrl #(.LANES(LANES), .PC_W(PC_W), .DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_pred(br_pred),
        .br_target_pc(br_target_pc), .br_fall_pc(br_fall_pc),
        .br_reconv_pc(br_reconv_pc), .path_done(path_done),
        .next_pc(next_pc), .active_mask(active_mask),
        .diverged(diverged), .stack_overflow(stack_overflow)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic state_is(input string req, input logic [PC_W-1:0] pc,
                            input logic [LANES-1:0] m, input logic dv);
        chk({req, " pc"}, 64'(next_pc), 64'(pc));
        chk({req, " mask"}, 64'(active_mask), 64'(m));
        chk({req, " diverged"}, 64'(diverged), 64'(dv));
    endtask

    // Drive one cycle of inputs at a falling edge; outputs are ready at the next falling edge
    task automatic cyc(input logic bv, input logic [LANES-1:0] p, input logic [PC_W-1:0] t,
                       input logic [PC_W-1:0] f, input logic [PC_W-1:0] r, input logic d);
        @(negedge clk);
        br_valid = bv; br_pred = p; br_target_pc = t; br_fall_pc = f;
        br_reconv_pc = r; path_done = d;
        @(negedge clk);
        br_valid = 1'b0; path_done = 1'b0; br_pred = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        br_valid = 1'b0; path_done = 1'b0; br_pred = '0;
        br_target_pc = '0; br_fall_pc = '0; br_reconv_pc = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        state_is("R1", 32'h0, FULL, 1'b0);
        chk("R1 overflow", 64'(stack_overflow), 64'd0);
    endtask

    task automatic t_uniform();
        do_reset();
        cyc(1, FULL, 32'h100, 32'h104, 32'h200, 0);
        state_is("R2 all taken", 32'h100, FULL, 1'b0);
        cyc(1, '0, 32'h300, 32'h304, 32'h400, 0);
        state_is("R2 none taken", 32'h304, FULL, 1'b0);
        // no entry was pushed: a path_done is still ignored
        cyc(0, '0, '0, '0, '0, 1);
        state_is("R2 no push", 32'h304, FULL, 1'b0);
    endtask

    task automatic t_split();
        do_reset();
        cyc(1, 32'h0000FFFF, 32'h40, 32'h80, 32'hC0, 0);
        state_is("R3 taken first", 32'h40, 32'h0000FFFF, 1'b1);
        cyc(0, '0, '0, '0, '0, 1);
        state_is("R4 other side", 32'h80, 32'hFFFF0000, 1'b1);
        cyc(0, '0, '0, '0, '0, 1);
        state_is("R5 reconverge", 32'hC0, FULL, 1'b0);
    endtask

    task automatic t_inactive_ignored();
        do_reset();
        cyc(1, 32'h0000FFFF, 32'h40, 32'h80, 32'hC0, 0);
        // active lanes 0..15 all 1, inactive lanes 16..31 a mix: uniform
        cyc(1, 32'hA5A5FFFF, 32'h50, 32'h54, 32'h58, 0);
        state_is("R6 uniform among active", 32'h50, 32'h0000FFFF, 1'b1);
        cyc(0, '0, '0, '0, '0, 1);
        state_is("R6 outer side two", 32'h80, 32'hFFFF0000, 1'b1);
        cyc(0, '0, '0, '0, '0, 1);
        state_is("R6 reconverge", 32'hC0, FULL, 1'b0);
    endtask

    task automatic t_nested();
        do_reset();
        cyc(1, 32'h0000FFFF, 32'h1000, 32'h2000, 32'h3000, 0);
        cyc(1, 32'hFFFF00FF, 32'h1100, 32'h1200, 32'h1300, 0);
        state_is("R7 inner taken", 32'h1100, 32'h000000FF, 1'b1);
        cyc(0, '0, '0, '0, '0, 1);
        state_is("R7 inner other", 32'h1200, 32'h0000FF00, 1'b1);
        cyc(0, '0, '0, '0, '0, 1);
        state_is("R7 inner reconverge", 32'h1300, 32'h0000FFFF, 1'b1);
        cyc(0, '0, '0, '0, '0, 1);
        state_is("R7 outer other", 32'h2000, 32'hFFFF0000, 1'b1);
        cyc(0, '0, '0, '0, '0, 1);
        state_is("R7 outer reconverge", 32'h3000, FULL, 1'b0);
    endtask

    task automatic t_idle_done();
        do_reset();
        cyc(1, FULL, 32'h77, 32'h78, 32'h79, 0);
        cyc(0, '0, '0, '0, '0, 1);
        state_is("R8 ignored", 32'h77, FULL, 1'b0);
    endtask

    task automatic t_collision();
        do_reset();
        cyc(1, 32'h000000F0, 32'h10, 32'h20, 32'h30, 0);
        cyc(1, 32'h00000030, 32'h44, 32'h48, 32'h4C, 1);
        state_is("R9 done served", 32'h20, 32'hFFFFFF0F, 1'b1);
        cyc(0, '0, '0, '0, '0, 1);
        state_is("R9 branch dropped", 32'h30, FULL, 1'b0);
    endtask

    task automatic t_overflow();
        logic [LANES-1:0] m;
        do_reset();
        m = FULL;
        for (int i = 0; i < DEPTH; i++) begin
            m = m & ~(m & (~m + 1'b1));
            cyc(1, m, PC_W'(32'h500 + i), 32'h600, 32'h700, 0);
        end
        state_is("R10 full stack", 32'h507, m, 1'b1);
        chk("R10 not yet", 64'(stack_overflow), 64'd0);
        cyc(1, m & ~(m & (~m + 1'b1)), 32'h900, 32'h904, 32'h908, 0);
        chk("R10 raised", 64'(stack_overflow), 64'd1);
        chk("R10 mask frozen", 64'(active_mask), 64'(m));
        chk("R10 pc frozen", 64'(next_pc), 64'h507);
        cyc(0, '0, '0, '0, '0, 1);
        cyc(1, FULL, 32'hABC, 32'hDEF, 32'h123, 0);
        chk("R10 sticky", 64'(stack_overflow), 64'd1);
        chk("R10 done ignored mask", 64'(active_mask), 64'(m));
        chk("R10 branch ignored pc", 64'(next_pc), 64'h507);
        do_reset();
        chk("R1 reset clears overflow", 64'(stack_overflow), 64'd0);
        chk("R1 reset mask", 64'(active_mask), 64'(FULL));
    endtask

    initial begin
        #(8ns * 200000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        br_valid = 1'b0; path_done = 1'b0; br_pred = '0;
        br_target_pc = '0; br_fall_pc = '0; br_reconv_pc = '0;
        t_reset();
        t_uniform();
        t_split();
        t_inactive_ignored();
        t_nested();
        t_idle_done();
        t_collision();
        t_overflow();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule